// File: doc/BRIEF.md
# Dual-Issue Load-Use Interlock

This block decides, once per cycle, whether the two instructions sitting in the decode/execute latch of a two-wide in-order pipeline may move on. The pipeline bypasses every result, so a load is the only producer that can hold anything up. The block compares the destination of each load in the execute/memory latch against both source registers of both decode slots. It also checks whether the younger decode instruction reads the register written by the older one in the same pair. Both slot valids take part in every comparison.

From these hazards it drives a stall for the older slot and a stall for the younger slot. It also raises a flag when the pair issues together, and a flag when the older instruction issues by itself. A stall on the older slot always stalls the younger slot too. The parameter `POLICY` chooses how a stall on the younger slot alone is handled. Under the rigid policy the whole pair is held. Under the fluid policy the older instruction moves on and the younger one waits; the pipeline then shifts the younger instruction into the older slot. All outputs are registered, so each decision appears one clock after the inputs it is based on.

Top module: `dual_issue_interlock`

## Requirements
- R1: While `rst` is high at a rising edge, all four outputs are 0 after that edge.
- R2: A valid load in either execute/memory slot whose destination equals `rs1` or `rs2` of the valid older decode slot (slot 0) sets both `stall_old` and `stall_young`.
- R3: A valid load whose destination equals a source of the valid younger decode slot (slot 1) sets `stall_young`. `stall_old` then follows the policy: it is set under rigid and clear under fluid, provided the older slot has no hazard of its own.
- R4: When the older slot is valid with `dx_old_wr` = 1 and the younger slot reads `dx_old_rd`, the pair does not issue together. In that case `stall_young` = 1, and `stall_old` is 1 under rigid and 0 under fluid.
- R5: Register number 0 never creates a dependence, whether it appears as a load destination or as the older slot's destination.
- R6: An execute/memory slot with its valid bit low, or a decode slot with its valid bit low, takes part in no comparison, as producer or as consumer.
- R7: An execute/memory instruction with `em_is_load` = 0 causes no stall. An older decode instruction with `dx_old_wr` = 0 (a store or a branch) is never a producer for the younger slot.
- R8: `pair_issue` is 1 exactly when both decode slots are valid and neither stall is set.
- R9: `old_alone` is 1 only under the fluid policy, and only when the older slot is valid, not stalled, and the younger slot is stalled. Under rigid it is always 0.
- R10: Outputs change only at a rising clock edge and reflect the inputs present just before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| em_valid | input | 2 | Valid bit of each execute/memory slot |
| em_is_load | input | 2 | Execute/memory slot holds a load |
| em_rd | input | 2 x REG_ADDR_W | Destination register of each execute/memory slot |
| dx_valid | input | 2 | Valid bit of each decode slot (0 older, 1 younger) |
| dx_rs1 | input | 2 x REG_ADDR_W | First source register of each decode slot |
| dx_rs2 | input | 2 x REG_ADDR_W | Second source register of each decode slot |
| dx_old_rd | input | REG_ADDR_W | Destination register of the older decode slot |
| dx_old_wr | input | 1 | Older decode slot writes a register |
| stall_old | output | 1 | Hold the older decode instruction |
| stall_young | output | 1 | Hold the younger decode instruction |
| pair_issue | output | 1 | Both decode instructions advance together |
| old_alone | output | 1 | Older instruction advances while the younger waits (fluid only) |

## Verification
A wrong hazard term inside the block shows up at the stall outputs one clock after the offending inputs, because the outputs are registered and nothing accumulates across cycles. A missing stall lets a dependent instruction pass; a spurious one drops `pair_issue` without cause. A policy error shows up as `stall_old` set on a younger-only hazard, or as `old_alone` being asserted under rigid. The bench runs a rigid and a fluid instance side by side on the same stimulus, so any divergence between the two policies is seen in the same cycle.

// File: rtl/ldu_pkg.sv
package ldu_pkg;
  typedef enum logic {
    POLICY_RIGID = 1'b0,
    POLICY_FLUID = 1'b1
  } stall_policy_e;

  localparam int unsigned PAIR_W = 2;
  localparam int unsigned SLOT_OLD = 0;
  localparam int unsigned SLOT_YOUNG = 1;
endpackage

// File: rtl/ldu_loaduse_cmp.sv
module ldu_loaduse_cmp #(
  parameter int unsigned RW = 5,
  parameter int unsigned NPROD = 2
) (
  input  logic [NPROD-1:0]         prod_valid,
  input  logic [NPROD-1:0]         prod_load,
  input  logic [NPROD-1:0][RW-1:0] prod_rd,
  input  logic                     cons_valid,
  input  logic [RW-1:0]            cons_rs1,
  input  logic [RW-1:0]            cons_rs2,
  output logic                     hit
);
  logic [NPROD-1:0] match;

  for (genvar p = 0; p < NPROD; p++) begin : g_prod
    logic live;
    assign live = prod_valid[p] && prod_load[p] && (prod_rd[p] != '0);
    assign match[p] = live && cons_valid &&
                      ((cons_rs1 == prod_rd[p]) || (cons_rs2 == prod_rd[p]));
  end

  assign hit = |match;
endmodule

// File: rtl/ldu_pair_dep.sv
module ldu_pair_dep #(
  parameter int unsigned RW = 5
) (
  input  logic          old_valid,
  input  logic          old_wr,
  input  logic [RW-1:0] old_rd,
  input  logic          young_valid,
  input  logic [RW-1:0] young_rs1,
  input  logic [RW-1:0] young_rs2,
  output logic          dep
);
  logic producer;
  assign producer = old_valid && old_wr && (old_rd != '0);
  assign dep = producer && young_valid &&
               ((young_rs1 == old_rd) || (young_rs2 == old_rd));
endmodule

// File: rtl/ldu_stall_policy.sv
module ldu_stall_policy
  import ldu_pkg::*;
#(
  parameter stall_policy_e POLICY = POLICY_RIGID
) (
  input  logic haz_old,
  input  logic haz_young,
  input  logic old_valid,
  input  logic young_valid,
  output logic stall_old,
  output logic stall_young,
  output logic pair_issue,
  output logic old_alone
);
  if (POLICY == POLICY_FLUID) begin : g_fluid
    assign stall_old   = haz_old;
    assign stall_young = haz_old || haz_young;
    assign old_alone   = old_valid && !haz_old && haz_young;
  end else begin : g_rigid
    logic any_haz;
    assign any_haz     = haz_old || haz_young;
    assign stall_old   = any_haz;
    assign stall_young = any_haz;
    assign old_alone   = 1'b0;
  end

  assign pair_issue = old_valid && young_valid && !stall_old && !stall_young;
endmodule

// File: rtl/dual_issue_interlock.sv
module dual_issue_interlock
  import ldu_pkg::*;
#(
  parameter int unsigned   REG_ADDR_W = 5,
  parameter stall_policy_e POLICY     = POLICY_RIGID
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic [PAIR_W-1:0]                em_valid,
  input  logic [PAIR_W-1:0]                em_is_load,
  input  logic [PAIR_W-1:0][REG_ADDR_W-1:0] em_rd,
  input  logic [PAIR_W-1:0]                dx_valid,
  input  logic [PAIR_W-1:0][REG_ADDR_W-1:0] dx_rs1,
  input  logic [PAIR_W-1:0][REG_ADDR_W-1:0] dx_rs2,
  input  logic [REG_ADDR_W-1:0]            dx_old_rd,
  input  logic                             dx_old_wr,
  output logic                             stall_old,
  output logic                             stall_young,
  output logic                             pair_issue,
  output logic                             old_alone
);
  logic [PAIR_W-1:0] lu_hit;
  logic              in_pair;
  logic              haz_old, haz_young;
  logic              nx_stall_old, nx_stall_young, nx_pair, nx_alone;

  for (genvar s = 0; s < PAIR_W; s++) begin : g_slot
    ldu_loaduse_cmp #(.RW(REG_ADDR_W), .NPROD(PAIR_W)) u_cmp (
      .prod_valid (em_valid),
      .prod_load  (em_is_load),
      .prod_rd    (em_rd),
      .cons_valid (dx_valid[s]),
      .cons_rs1   (dx_rs1[s]),
      .cons_rs2   (dx_rs2[s]),
      .hit        (lu_hit[s])
    );
  end

  ldu_pair_dep #(.RW(REG_ADDR_W)) u_dep (
    .old_valid   (dx_valid[SLOT_OLD]),
    .old_wr      (dx_old_wr),
    .old_rd      (dx_old_rd),
    .young_valid (dx_valid[SLOT_YOUNG]),
    .young_rs1   (dx_rs1[SLOT_YOUNG]),
    .young_rs2   (dx_rs2[SLOT_YOUNG]),
    .dep         (in_pair)
  );

  assign haz_old   = lu_hit[SLOT_OLD];
  assign haz_young = lu_hit[SLOT_YOUNG] || in_pair;

  ldu_stall_policy #(.POLICY(POLICY)) u_pol (
    .haz_old     (haz_old),
    .haz_young   (haz_young),
    .old_valid   (dx_valid[SLOT_OLD]),
    .young_valid (dx_valid[SLOT_YOUNG]),
    .stall_old   (nx_stall_old),
    .stall_young (nx_stall_young),
    .pair_issue  (nx_pair),
    .old_alone   (nx_alone)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      stall_old   <= 1'b0;
      stall_young <= 1'b0;
      pair_issue  <= 1'b0;
      old_alone   <= 1'b0;
    end else begin
      stall_old   <= nx_stall_old;
      stall_young <= nx_stall_young;
      pair_issue  <= nx_pair;
      old_alone   <= nx_alone;
    end
  end
endmodule

// File: rtl/ldu_interlock_props.sv
module ldu_interlock_props
  import ldu_pkg::*;
#(
  parameter int unsigned   RW     = 5,
  parameter stall_policy_e POLICY = POLICY_RIGID
) (
  input logic                     clk,
  input logic                     rst,
  input logic [PAIR_W-1:0][RW-1:0] em_rd,
  input logic [RW-1:0]            dx_old_rd,
  input logic                     stall_old,
  input logic                     stall_young,
  input logic                     pair_issue,
  input logic                     old_alone
);
  AST_YOUNG_FOLLOWS_OLD: assert property (@(posedge clk) disable iff (rst)
    stall_old |-> stall_young); // R2

  AST_RIGID_HOLDS_PAIR: assert property (@(posedge clk) disable iff (rst)
    (stall_young && POLICY == POLICY_RIGID) |-> stall_old); // R3

  AST_PAIR_NOT_STALLED: assert property (@(posedge clk) disable iff (rst)
    pair_issue |-> (!stall_old && !stall_young)); // R8

  AST_ALONE_FLUID_ONLY: assert property (@(posedge clk) disable iff (rst)
    old_alone |-> (POLICY == POLICY_FLUID && !stall_old && stall_young)); // R9

  AST_ZERO_REG_QUIET: assert property (@(posedge clk) disable iff (rst)
    (em_rd[0] == '0 && em_rd[1] == '0 && dx_old_rd == '0)
      |=> (!stall_old && !stall_young)); // R5
endmodule

bind dual_issue_interlock ldu_interlock_props #(.RW(REG_ADDR_W), .POLICY(POLICY)) u_props (
  .clk         (clk),
  .rst         (rst),
  .em_rd       (em_rd),
  .dx_old_rd   (dx_old_rd),
  .stall_old   (stall_old),
  .stall_young (stall_young),
  .pair_issue  (pair_issue),
  .old_alone   (old_alone)
);

// File: tb/dual_issue_interlock_test.sv
module dual_issue_interlock_test;
  import ldu_pkg::*;

  localparam int RW = 5;
  localparam int NVEC = 14;
  localparam int VW = 50;

  // {em_valid, em_is_load, em_rd1, em_rd0, dx_valid, old_wr,
  //  y_rs1, y_rs2, o_rs1, o_rs2, o_rd, rigid{so,sy,pi,oa}, fluid{so,sy,pi,oa}}
  localparam logic [VW-1:0] VEC [NVEC] = '{
    {2'b00,2'b00,5'd0,5'd0,2'b11,1'b1,5'd4,5'd5,5'd1,5'd2,5'd3,4'b0010,4'b0010},
    {2'b01,2'b01,5'd0,5'd7,2'b11,1'b1,5'd4,5'd5,5'd7,5'd2,5'd3,4'b1100,4'b1100},
    {2'b10,2'b10,5'd9,5'd0,2'b11,1'b1,5'd4,5'd5,5'd1,5'd9,5'd3,4'b1100,4'b1100},
    {2'b01,2'b01,5'd0,5'd5,2'b11,1'b1,5'd4,5'd5,5'd1,5'd2,5'd3,4'b1100,4'b0101},
    {2'b10,2'b10,5'd4,5'd0,2'b11,1'b1,5'd4,5'd5,5'd1,5'd2,5'd3,4'b1100,4'b0101},
    {2'b00,2'b00,5'd0,5'd0,2'b11,1'b1,5'd3,5'd5,5'd1,5'd2,5'd3,4'b1100,4'b0101},
    {2'b00,2'b00,5'd0,5'd0,2'b11,1'b0,5'd3,5'd5,5'd1,5'd2,5'd3,4'b0010,4'b0010},
    {2'b01,2'b01,5'd0,5'd0,2'b11,1'b1,5'd0,5'd5,5'd0,5'd2,5'd0,4'b0010,4'b0010},
    {2'b00,2'b01,5'd0,5'd1,2'b11,1'b1,5'd4,5'd5,5'd1,5'd2,5'd3,4'b0010,4'b0010},
    {2'b01,2'b00,5'd0,5'd1,2'b11,1'b1,5'd4,5'd5,5'd1,5'd2,5'd3,4'b0010,4'b0010},
    {2'b01,2'b01,5'd0,5'd4,2'b10,1'b1,5'd4,5'd5,5'd1,5'd2,5'd3,4'b1100,4'b0100},
    {2'b00,2'b00,5'd0,5'd0,2'b10,1'b1,5'd3,5'd5,5'd1,5'd2,5'd3,4'b0000,4'b0000},
    {2'b11,2'b11,5'd5,5'd1,2'b11,1'b1,5'd4,5'd5,5'd1,5'd2,5'd3,4'b1100,4'b1100},
    {2'b01,2'b01,5'd0,5'd4,2'b01,1'b1,5'd4,5'd5,5'd1,5'd2,5'd3,4'b0000,4'b0000}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0]         em_valid = '0, em_is_load = '0, dx_valid = '0;
  logic [1:0][RW-1:0] em_rd = '0, dx_rs1 = '0, dx_rs2 = '0;
  logic [RW-1:0]      dx_old_rd = '0;
  logic               dx_old_wr = 1'b0;
  logic so_r, sy_r, pi_r, oa_r, so_f, sy_f, pi_f, oa_f;
  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  dual_issue_interlock #(.REG_ADDR_W(RW), .POLICY(POLICY_RIGID)) uut (
    .clk(clk), .rst(rst), .em_valid(em_valid), .em_is_load(em_is_load),
    .em_rd(em_rd), .dx_valid(dx_valid), .dx_rs1(dx_rs1), .dx_rs2(dx_rs2),
    .dx_old_rd(dx_old_rd), .dx_old_wr(dx_old_wr),
    .stall_old(so_r), .stall_young(sy_r), .pair_issue(pi_r), .old_alone(oa_r));

  dual_issue_interlock #(.REG_ADDR_W(RW), .POLICY(POLICY_FLUID)) uut_fluid (
    .clk(clk), .rst(rst), .em_valid(em_valid), .em_is_load(em_is_load),
    .em_rd(em_rd), .dx_valid(dx_valid), .dx_rs1(dx_rs1), .dx_rs2(dx_rs2),
    .dx_old_rd(dx_old_rd), .dx_old_wr(dx_old_wr),
    .stall_old(so_f), .stall_young(sy_f), .pair_issue(pi_f), .old_alone(oa_f));

  function automatic string vec_tag(int i);
    case (i)
      0: return "R8 independent pair";
      1, 2, 12: return "R2 load-use on older slot";
      3, 4: return "R3 R9 load-use on younger slot";
      5: return "R4 in-pair dependence";
      6: return "R7 older slot does not write";
      7: return "R5 register zero";
      8: return "R6 invalid execute/memory slot";
      9: return "R7 non-load producer";
      10, 11, 13: return "R6 invalid decode slot";
      default: return "R8";
    endcase
  endfunction

  task automatic check(string req, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual {so,sy,pi,oa}=%b expected %b", req, act, exp);
    end
  endtask

  task automatic drive(logic [VW-1:0] v);
    em_valid   = v[49:48];
    em_is_load = v[47:46];
    em_rd      = {v[45:41], v[40:36]};
    dx_valid   = v[35:34];
    dx_old_wr  = v[33];
    dx_rs1     = {v[32:28], v[22:18]};
    dx_rs2     = {v[27:23], v[17:13]};
    dx_old_rd  = v[12:8];
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2;
    check("R1 reset rigid", {so_r, sy_r, pi_r, oa_r}, 4'b0000);
    check("R1 reset fluid", {so_f, sy_f, pi_f, oa_f}, 4'b0000);
    @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      drive(VEC[i]);
      @(posedge clk);
      #2;
      check({vec_tag(i), " rigid"}, {so_r, sy_r, pi_r, oa_r}, VEC[i][7:4]);
      check({vec_tag(i), " fluid"}, {so_f, sy_f, pi_f, oa_f}, VEC[i][3:0]);
    end

    // R10: new inputs are not visible before the clock edge
    @(negedge clk);
    drive(VEC[1]);
    #2;
    check("R10 before edge rigid", {so_r, sy_r, pi_r, oa_r}, 4'b0000);
    @(posedge clk);
    #2;
    check("R10 after edge rigid", {so_r, sy_r, pi_r, oa_r}, 4'b1100);

    // R1: reset while a hazard is present
    @(negedge clk);
    drive(VEC[3]);
    rst = 1'b1;
    @(posedge clk);
    #2;
    check("R1 reset over hazard rigid", {so_r, sy_r, pi_r, oa_r}, 4'b0000);
    check("R1 reset over hazard fluid", {so_f, sy_f, pi_f, oa_f}, 4'b0000);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    #2;
    check("R3 after reset fluid", {so_f, sy_f, pi_f, oa_f}, 4'b0101);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule